// File: doc/BRIEF.md
# Serial Interrupt Status Unit with Clear-on-Read

This block gathers single-cycle event pulses from the rest of a measurement chip into an interrupt flag register. A separate enable register decides which flags may pull the active-low interrupt line low. A host reaches both registers through a four-wire serial slave port that works in 8-bit bytes. Each transaction is one command byte followed by one data byte. All serial pins are synchronized into the system clock, which must run well above the serial clock.

The key operation is an atomic read-and-clear of the flags. When the command byte of such a read completes, the flag value is captured for shifting out and the interrupt line is forced inactive. The line is held inactive until the last data bit has been shifted out. At that point only the flags that were captured are cleared. Any event that arrived during the read survives and can assert the line again straight away. If a transaction is cut short, nothing is cleared and nothing is written.

Top module: `irq_status_unit`

## Requirements
- R1: After reset, the flag and enable registers hold zero, `irq_n` is 1 and `dout` is 0.
- R2: A 1 on `evt[i]` for one clock sets flag i, whatever enable bit i holds. A flag set while its enable bit is 0 leaves `irq_n` at 1.
- R3: Outside a read-and-clear window, `irq_n` is 0 exactly when some flag bit and its matching enable bit are both 1.
- R4: Command byte format: bit 7 is 1 for a write and 0 for a read, and bits 5:0 hold the address. The enable register sits at address 0x0A and can be written and read back. The port uses serial mode 1: the device samples `din` on falling `sclk` edges and changes `dout` after rising edges. Bytes travel MSB first.
- R5: A read of address 0x04 returns the flags and leaves them unchanged.
- R6: A read of address 0x05 returns the flags as they stood when the command byte ended. Once the data byte completes, it clears exactly those returned bits.
- R7: During a read of address 0x05, `irq_n` is 1 from the last falling `sclk` edge of the command byte until the last falling `sclk` edge of the data byte, even when enabled flags are set.
- R8: An event that arrives during a read of address 0x05 is never lost, even when it hits a bit being cleared. If that event is enabled, `irq_n` returns to 0 once the data byte ends.
- R9: If `cs_n` rises before the 16th falling `sclk` edge, the transaction is aborted. No flag is cleared, the enable register is not written, and `irq_n` again follows R3.
- R10: Writes to addresses 0x04 and 0x05 have no effect on the flags.
- R11: A read of any address other than 0x04, 0x05 or 0x0A returns 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt | input | NSRC | Event pulses, one bit per interrupt source |
| cs_n | input | 1 | Serial chip select, active low |
| sclk | input | 1 | Serial clock from the host |
| din | input | 1 | Serial data from the host |
| dout | output | 1 | Serial data to the host |
| irq_n | output | 1 | Interrupt request, active low |

## Verification
Several properties are checked on every cycle:
- An event always leaves its flag set on the next cycle.
- No flag ever falls except at the end of a completed read-and-clear.
- A completed read-and-clear removes only captured bits and keeps every late arrival.
- The hold window can only open at the command-byte boundary, and it closes whenever chip select goes inactive.
- A low `irq_n` always has an enabled flag behind it.

Other behaviours depend on what the host shifts in and reads back, so only the bench scenarios can show them:
- the exact bytes returned for each address;
- `irq_n` staying high across a read while an enabled late event waits;
- aborted writes leaving the enable register untouched;
- writes to the flag addresses being ignored.

// File: rtl/irq_status_unit.sv
module irq_status_unit #(
  parameter int NSRC = 8,
  parameter logic [5:0] A_STAT = 6'h04,
  parameter logic [5:0] A_CLR  = 6'h05,
  parameter logic [5:0] A_MASK = 6'h0A
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] evt,
  input  logic            cs_n,
  input  logic            sclk,
  input  logic            din,
  output logic            dout,
  output logic            irq_n
);

  localparam int BYTE = 8;
  localparam int CW = $clog2(2*BYTE+1);
  localparam logic [CW-1:0] CMD_LAST  = CW'(BYTE-1);
  localparam logic [CW-1:0] DATA_LAST = CW'(2*BYTE-1);
  localparam logic [CW-1:0] DONE      = CW'(2*BYTE);

  logic [1:0] cs_q, din_q;
  logic [2:0] sclk_q;
  logic [CW-1:0] cnt;
  logic [BYTE-2:0] rx;
  logic [BYTE-1:0] tx, rd_byte;
  logic [NSRC-1:0] status, mask, snap, late;
  logic hold, wr_q, dout_r;
  logic [5:0] ad_q;

  wire active = ~cs_q[1];
  wire rise   = sclk_q[1] & ~sclk_q[2];
  wire fall   = ~sclk_q[1] & sclk_q[2];
  wire din_s  = din_q[1];
  wire [BYTE-1:0] byte_in = {rx, din_s};
  wire cmd_wr = byte_in[7];
  wire [5:0] cmd_ad = byte_in[5:0];

  wire step      = active & fall & (cnt < DONE);
  wire cmd_end   = step & (cnt == CMD_LAST);
  wire data_end  = step & (cnt == DATA_LAST);
  wire rd_done   = data_end & hold;
  wire start_clr = cmd_end & ~cmd_wr & (cmd_ad == A_CLR);

  always_comb begin
    rd_byte = '0;
    if (cmd_ad == A_STAT || cmd_ad == A_CLR) rd_byte[NSRC-1:0] = status;
    else if (cmd_ad == A_MASK)              rd_byte[NSRC-1:0] = mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q   <= 2'b11;
      sclk_q <= '0;
      din_q  <= '0;
    end else begin
      cs_q   <= {cs_q[0], cs_n};
      sclk_q <= {sclk_q[1:0], sclk};
      din_q  <= {din_q[0], din};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      rx     <= '0;
      tx     <= '0;
      dout_r <= 1'b0;
      wr_q   <= 1'b0;
      ad_q   <= '0;
      hold   <= 1'b0;
      status <= '0;
      mask   <= '0;
      snap   <= '0;
      late   <= '0;
    end else begin
      status <= rd_done ? ((status & ~snap) | late | evt) : (status | evt);
      if (start_clr)  late <= evt;
      else if (hold)  late <= late | evt;
      if (!active) begin
        cnt    <= '0;
        hold   <= 1'b0;
        dout_r <= 1'b0;
      end else begin
        if (step) begin
          rx  <= byte_in[BYTE-2:0];
          cnt <= cnt + 1'b1;
        end
        if (cmd_end) begin
          wr_q <= cmd_wr;
          ad_q <= cmd_ad;
          tx   <= cmd_wr ? '0 : rd_byte;
        end
        if (start_clr) begin
          snap <= status;
          hold <= 1'b1;
        end
        if (data_end) begin
          hold <= 1'b0;
          if (wr_q && ad_q == A_MASK) mask <= byte_in[NSRC-1:0];
        end
        if (rise && cnt > CMD_LAST && cnt < DONE) begin
          dout_r <= tx[BYTE-1];
          tx     <= {tx[BYTE-2:0], 1'b0};
        end
      end
    end
  end

  assign dout  = dout_r;
  assign irq_n = hold | ~|(status & mask);

  AST_FLAG_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt) |=> ((status & $past(evt)) == $past(evt)));                  // R2
  AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n |-> (|(status & mask)));                                      // R3
  AST_NO_STRAY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_done |=> ((~status & $past(status)) == '0));                     // R5
  AST_CLEAR_CAPTURED: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done |=> ((status & $past(snap) & ~$past(late | evt)) == '0));    // R6
  AST_HOLD_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold) |-> (cnt == CW'(BYTE)));                                 // R7
  AST_LATE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done |=> ((status & $past(late)) == $past(late)));                // R8
  AST_ABORT_DROPS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> !hold);                                                  // R9

endmodule

// File: tb/irq_status_unit_test.sv
`timescale 1ns/1ps
module irq_status_unit_test;
  localparam int H = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] evt = '0;
  logic cs_n = 1'b1, sclk = 1'b0, din = 1'b0;
  logic dout, irq_n;

  irq_status_unit uut (.clk(clk), .rst_n(rst_n), .evt(evt), .cs_n(cs_n),
                       .sclk(sclk), .din(din), .dout(dout), .irq_n(irq_n));

  always #4 clk = ~clk;

  int errs = 0, checks = 0;
  bit done = 0, cmp_en = 0;
  logic [7:0] mstat = '0, mmask = '0;

  task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    #1;
    if (cmp_en && !done) chk(irq_n == ~|(mstat & mmask), "R3 per-cycle irq_n", {7'd0, irq_n}, {7'd0, ~|(mstat & mmask)});
  end

  task automatic pulse(input logic [7:0] m);
    @(negedge clk) evt = m;
    @(negedge clk) evt = '0;
    mstat = mstat | m;
  endtask

  task automatic shift_bit(input logic b, output logic o);
    @(negedge clk) begin sclk = 1'b1; din = b; end
    repeat (H) @(negedge clk);
    o = dout;
    sclk = 1'b0;
    repeat (H) @(negedge clk);
  endtask

  task automatic xfer(input logic [7:0] c, input logic [7:0] w, input int nbits, output logic [7:0] r);
    logic o;
    cmp_en = 0;
    r = '0;
    @(negedge clk) cs_n = 1'b0;
    repeat (H) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      shift_bit(i < 8 ? c[7-i] : w[15-i], o);
      if (i >= 8) r[15-i] = o;
    end
    @(negedge clk) cs_n = 1'b1;
    repeat (H) @(negedge clk);
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
    cmp_en = 1;
  endtask

  task automatic finish_run();
    if (done) return;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errs++;
      $display("FAIL watchdog: actual=%h expected=%h", 8'h00, 8'h01);
      finish_run();
    end
  end

  initial begin
    logic [7:0] r;
    logic o;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(irq_n === 1'b1, "R1 irq_n after reset", {7'd0, irq_n}, 8'h01);
    chk(dout === 1'b0, "R1 dout after reset", {7'd0, dout}, 8'h00);
    xfer(8'h04, 8'h00, 16, r); chk(r == 8'h00, "R1 flags zero", r, 8'h00);
    xfer(8'h0A, 8'h00, 16, r); chk(r == 8'h00, "R1 enable zero", r, 8'h00);
    settle();

    pulse(8'h05);
    repeat (2) @(negedge clk);
    chk(irq_n == 1'b1, "R2 masked flag keeps irq_n high", {7'd0, irq_n}, 8'h01);
    xfer(8'h04, 8'h00, 16, r); chk(r == 8'h05, "R2 flags set while masked", r, 8'h05);
    xfer(8'h04, 8'h00, 16, r); chk(r == 8'h05, "R5 plain read keeps flags", r, 8'h05);

    xfer(8'h8A, 8'h04, 16, r); mmask = 8'h04;
    xfer(8'h0A, 8'h00, 16, r); chk(r == 8'h04, "R4 enable readback", r, 8'h04);
    settle();
    repeat (2) @(negedge clk);
    chk(irq_n == 1'b0, "R3 enabled flag drives irq_n", {7'd0, irq_n}, 8'h00);
    pulse(8'h01);
    xfer(8'h8A, 8'hA5, 16, r); mmask = 8'hA5;
    xfer(8'h0A, 8'h00, 16, r); chk(r == 8'hA5, "R4 MSB-first pattern", r, 8'hA5);
    xfer(8'h8A, 8'h04, 16, r); mmask = 8'h04;
    settle();

    cmp_en = 0;
    r = '0;
    @(negedge clk) cs_n = 1'b0;
    repeat (H) @(negedge clk);
    for (int i = 0; i < 8; i++) shift_bit(8'h05 >> (7 - i), o);
    chk(irq_n == 1'b1, "R7 irq_n high after command byte", {7'd0, irq_n}, 8'h01);
    for (int i = 8; i < 16; i++) begin
      if (i == 11) begin pulse(8'h40); pulse(8'h04); end
      shift_bit(1'b0, o);
      r[15-i] = o;
      if (i == 14) chk(irq_n == 1'b1, "R7 irq_n high before last data bit", {7'd0, irq_n}, 8'h01);
    end
    @(negedge clk) cs_n = 1'b1;
    repeat (H) @(negedge clk);
    chk(r == 8'h05, "R6 read-and-clear returns captured flags", r, 8'h05);
    chk(irq_n == 1'b0, "R8 late enabled event re-asserts irq_n", {7'd0, irq_n}, 8'h00);
    mstat = 8'h44;
    settle();
    xfer(8'h04, 8'h00, 16, r); chk(r == 8'h44, "R8 late events kept, R6 others cleared", r, 8'h44);

    xfer(8'h05, 8'h00, 16, r); chk(r == 8'h44, "R6 second read-and-clear", r, 8'h44);
    mstat = 8'h00;
    xfer(8'h04, 8'h00, 16, r); chk(r == 8'h00, "R6 flags empty after clear", r, 8'h00);
    settle();
    xfer(8'h05, 8'h00, 16, r); chk(r == 8'h00, "R6 empty read-and-clear", r, 8'h00);
    chk(irq_n == 1'b1, "R7 irq_n high with nothing pending", {7'd0, irq_n}, 8'h01);
    settle();

    pulse(8'h10);
    xfer(8'h8A, 8'h10, 16, r); mmask = 8'h10;
    settle();
    cmp_en = 0;
    @(negedge clk) cs_n = 1'b0;
    repeat (H) @(negedge clk);
    for (int i = 0; i < 12; i++) shift_bit(8'h05 >> (7 - (i & 7)), o);
    chk(irq_n == 1'b1, "R7 irq_n held mid data byte", {7'd0, irq_n}, 8'h01);
    @(negedge clk) cs_n = 1'b1;
    repeat (H) @(negedge clk);
    chk(irq_n == 1'b0, "R9 abort restores irq_n", {7'd0, irq_n}, 8'h00);
    xfer(8'h04, 8'h00, 16, r); chk(r == 8'h10, "R9 abort clears nothing", r, 8'h10);
    xfer(8'h8A, 8'hFF, 12, r);
    xfer(8'h0A, 8'h00, 16, r); chk(r == 8'h10, "R9 aborted write leaves enable", r, 8'h10);
    settle();

    xfer(8'h85, 8'h00, 16, r);
    xfer(8'h84, 8'hFF, 16, r);
    xfer(8'h04, 8'h00, 16, r); chk(r == 8'h10, "R10 writes to flag addresses ignored", r, 8'h10);
    xfer(8'h11, 8'h00, 16, r); chk(r == 8'h00, "R11 unknown address reads zero", r, 8'h00);
    xfer(8'h3F, 8'h00, 16, r); chk(r == 8'h00, "R11 top address reads zero", r, 8'h00);
    settle();
    repeat (10) @(negedge clk);
    finish_run();
  end
endmodule